// File: doc/BRIEF.md
# Cascadable Multiplier Operand Stage

This block is the operand side of half a multiply slice. It holds four signed multiplier lanes, each with an A operand bank and a B operand bank. Every lane forms a full-width signed product, and an output bank registers that product. At build time the A banks are set up in one of two ways. They can load from their own input lanes, or they can be chained into a tap delay line. The chain enters at a scan input and leaves at a scan output. Joining the scan output of one instance to the scan input of the next makes a longer delay line, which suits FIR filters.

Lane 0's B bank can be built with a recursion path. While a run-time select is high, that bank reloads from the upper half of lane 0's registered result instead of its input lane. A separate delay bank follows the scan output by one cycle, so that chained cascades can balance their latency.

Each bank takes one of four clocks, one of four enables and one of four asynchronous clears, each index chosen by a parameter. Any operand bank outside the chain can be bypassed by a static mask. The shift chain and the recursion path exist only when the operand width is 18 bits. At any other width the block falls back to parallel operands.

Top module: `opnd_stage`

## Requirements
- R1: While a bank's asynchronous clear is high, that bank reads zero at once, with no clock edge needed. Every bank reads zero after a clear of all four indices.
- R2: A bank whose selected enable is low keeps its value across clock edges, whatever its data input does.
- R3: In shift mode, A bank 0 loads scan_in_i and A bank k loads A bank k-1. scan_out_o is A bank NMUL-1. Two instances in series, each with constant B coefficients, yield res lanes whose sum equals sum over j of c_j * x[n-2-j].
- R4: In parallel mode, A bank k loads a_i bits [18k+17:18k], and B bank k loads b_i bits [18k+17:18k].
- R5: prod_o bits [36k+35:36k] equal the signed 36-bit product of lane k's A and B operands.
- R6: A lane whose bit in A_REG_MASK or B_REG_MASK is 0 feeds that operand from the input port straight to the multiplier. The product then changes without a clock edge.
- R7: res_o lane k equals prod_o lane k as it was at the previous enabled edge of the output bank.
- R8: With B0_LOOP set and b0_loop_i high, B bank 0 loads res_o bits [35:18]. b_i lane 0 is then ignored.
- R9: dly_o equals scan_out_o as it was at the previous enabled edge of the delay bank.
- R10: By default, the A banks use clock, enable and clear index 0, the B banks index 1, the delay bank index 2 and the output bank index 3. Lowering one enable stops only the banks mapped to that index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 4 | Clock choices for the banks |
| ena_i | input | 4 | Enable choices for the banks |
| aclr_i | input | 4 | Asynchronous clear choices, active high |
| a_i | input | NMUL*OPW | Parallel A operand lanes |
| b_i | input | NMUL*OPW | B operand lanes |
| scan_in_i | input | OPW | Shift chain input to A bank 0 |
| b0_loop_i | input | 1 | Selects recursion into B bank 0 |
| scan_out_o | output | OPW | Last A bank, for the next instance |
| dly_o | output | OPW | Scan output delayed by one bank |
| prod_o | output | NMUL*2*OPW | Signed products, one lane each |
| res_o | output | NMUL*2*OPW | Registered products |

## Verification
The bound properties check four things on every edge: the output bank tracks the products, the delay bank tracks the chain end, a disabled A bank holds the chain end steady, and an active clear zeroes the result and chain banks. Other behaviours only the bench scenarios can show. These are the filter sum across two chained instances, the recursion sequence through lane 0's B bank and the combinational path of bypassed operands. They also include the independence of enable indices, which is seen by stalling the B banks while the chain keeps moving.

// File: rtl/opnd_pkg.sv
package opnd_pkg;

    typedef logic [1:0] ctl_idx_t;

    // Field k of a packed index map, two bits per bank
    function automatic ctl_idx_t pick_idx(input logic [31:0] map, input int unsigned k);
        return map[2*k +: 2];
    endfunction

endpackage

// File: rtl/opnd_bank.sv
module opnd_bank #(
    parameter int unsigned W = 18
) (
    input  logic         clk,
    input  logic         en,
    input  logic         clr,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);

    always_ff @(posedge clk or posedge clr) begin
        if (clr) begin
            q <= '0;
        end else if (en) begin
            q <= d;
        end
    end

endmodule

// File: rtl/lane_mul.sv
module lane_mul #(
    parameter int unsigned W = 18
) (
    input  logic [W-1:0]   a,
    input  logic [W-1:0]   b,
    output logic [2*W-1:0] p
);

    logic signed [2*W-1:0] ax;
    logic signed [2*W-1:0] bx;

    assign ax = {{W{a[W-1]}}, a};
    assign bx = {{W{b[W-1]}}, b};
    assign p  = ax * bx;

endmodule

// File: rtl/opnd_stage.sv
module opnd_stage
    import opnd_pkg::*;
#(
    parameter int unsigned      OPW        = 18,
    parameter int unsigned      NMUL       = 4,
    parameter bit               A_SHIFT    = 1'b1,
    parameter bit               B0_LOOP    = 1'b0,
    parameter logic [NMUL-1:0]  A_REG_MASK = '1,
    parameter logic [NMUL-1:0]  B_REG_MASK = '1,
    parameter logic [31:0]      A_CLK_MAP  = 32'h0000_0000,
    parameter logic [31:0]      A_ENA_MAP  = 32'h0000_0000,
    parameter logic [31:0]      A_CLR_MAP  = 32'h0000_0000,
    parameter logic [31:0]      B_CLK_MAP  = 32'h5555_5555,
    parameter logic [31:0]      B_ENA_MAP  = 32'h5555_5555,
    parameter logic [31:0]      B_CLR_MAP  = 32'h5555_5555,
    parameter int unsigned      D_CLK      = 2,
    parameter int unsigned      D_ENA      = 2,
    parameter int unsigned      D_CLR      = 2,
    parameter int unsigned      O_CLK      = 3,
    parameter int unsigned      O_ENA      = 3,
    parameter int unsigned      O_CLR      = 3
) (
    input  logic [3:0]             clk_i,
    input  logic [3:0]             ena_i,
    input  logic [3:0]             aclr_i,
    input  logic [NMUL*OPW-1:0]    a_i,
    input  logic [NMUL*OPW-1:0]    b_i,
    input  logic [OPW-1:0]         scan_in_i,
    input  logic                   b0_loop_i,
    output logic [OPW-1:0]         scan_out_o,
    output logic [OPW-1:0]         dly_o,
    output logic [NMUL*2*OPW-1:0]  prod_o,
    output logic [NMUL*2*OPW-1:0]  res_o
);

    // Chain and recursion exist only at the full 18-bit width
    localparam bit          SHIFT_ON = A_SHIFT && (OPW == 18);
    localparam bit          LOOP_ON  = B0_LOOP && (OPW == 18);
    localparam int unsigned PW       = 2 * OPW;

    logic [OPW-1:0] a_d  [NMUL];
    logic [OPW-1:0] a_q  [NMUL];
    logic [OPW-1:0] a_op [NMUL];
    logic [OPW-1:0] b_d  [NMUL];
    logic [OPW-1:0] b_q  [NMUL];
    logic [OPW-1:0] b_op [NMUL];
    logic [PW-1:0]  p_w  [NMUL];
    logic [PW-1:0]  r_q  [NMUL];

    for (genvar k = 0; k < NMUL; k++) begin : g_lane
        localparam ctl_idx_t ACK = pick_idx(A_CLK_MAP, k);
        localparam ctl_idx_t AEN = pick_idx(A_ENA_MAP, k);
        localparam ctl_idx_t ACL = pick_idx(A_CLR_MAP, k);
        localparam ctl_idx_t BCK = pick_idx(B_CLK_MAP, k);
        localparam ctl_idx_t BEN = pick_idx(B_ENA_MAP, k);
        localparam ctl_idx_t BCL = pick_idx(B_CLR_MAP, k);

        // A operand source: chain tap or own lane
        if (SHIFT_ON) begin : g_chain
            if (k == 0) begin : g_head
                assign a_d[k] = scan_in_i;
            end else begin : g_tap
                assign a_d[k] = a_q[k-1];
            end
            assign a_op[k] = a_q[k];
        end else begin : g_par
            assign a_d[k] = a_i[k*OPW +: OPW];
            if (A_REG_MASK[k]) begin : g_areg
                assign a_op[k] = a_q[k];
            end else begin : g_abyp
                assign a_op[k] = a_i[k*OPW +: OPW];
            end
        end

        // B operand source: recursion only on lane 0
        if (LOOP_ON && (k == 0)) begin : g_loop
            assign b_d[k] = b0_loop_i ? r_q[0][PW-1 -: OPW] : b_i[k*OPW +: OPW];
        end else begin : g_bin
            assign b_d[k] = b_i[k*OPW +: OPW];
        end

        if (B_REG_MASK[k]) begin : g_breg
            assign b_op[k] = b_q[k];
        end else begin : g_bbyp
            assign b_op[k] = b_d[k];
        end

        opnd_bank #(.W(OPW)) u_abank (
            .clk (clk_i[ACK]),
            .en  (ena_i[AEN]),
            .clr (aclr_i[ACL]),
            .d   (a_d[k]),
            .q   (a_q[k])
        );

        opnd_bank #(.W(OPW)) u_bbank (
            .clk (clk_i[BCK]),
            .en  (ena_i[BEN]),
            .clr (aclr_i[BCL]),
            .d   (b_d[k]),
            .q   (b_q[k])
        );

        lane_mul #(.W(OPW)) u_mul (
            .a (a_op[k]),
            .b (b_op[k]),
            .p (p_w[k])
        );

        opnd_bank #(.W(PW)) u_obank (
            .clk (clk_i[O_CLK]),
            .en  (ena_i[O_ENA]),
            .clr (aclr_i[O_CLR]),
            .d   (p_w[k]),
            .q   (r_q[k])
        );

        assign prod_o[k*PW +: PW] = p_w[k];
        assign res_o[k*PW +: PW]  = r_q[k];
    end

    assign scan_out_o = a_q[NMUL-1];

    // Ninth bank: latency balance behind the chain end
    opnd_bank #(.W(OPW)) u_dbank (
        .clk (clk_i[D_CLK]),
        .en  (ena_i[D_ENA]),
        .clr (aclr_i[D_CLR]),
        .d   (a_q[NMUL-1]),
        .q   (dly_o)
    );

    logic unused_inputs;
    assign unused_inputs = ^{a_i, scan_in_i, b0_loop_i};

endmodule

// File: rtl/opnd_stage_chk.sv
module opnd_stage_chk #(
    parameter int unsigned OPW  = 18,
    parameter int unsigned NMUL = 4
) (
    input logic                  clk,
    input logic [3:0]            ena,
    input logic [3:0]            aclr,
    input logic [OPW-1:0]        scan_out,
    input logic [OPW-1:0]        dly,
    input logic [NMUL*2*OPW-1:0] prod,
    input logic [NMUL*2*OPW-1:0] res
);

    // Checks assume the default bank index maps (A 0, B 1, delay 2, output 3)
    assert_out_follow_R7: assert property (@(posedge clk) disable iff (aclr[3])
        ena[3] |=> res == $past(prod));

    assert_dly_follow_R9: assert property (@(posedge clk) disable iff (aclr[2])
        ena[2] |=> dly == $past(scan_out));

    assert_chain_hold_R2: assert property (@(posedge clk) disable iff (aclr[0])
        !ena[0] |=> $stable(scan_out));

    assert_clr_res_R1: assert property (@(posedge clk)
        aclr[3] |-> res == '0);

    assert_clr_chain_R1: assert property (@(posedge clk)
        aclr[0] |-> scan_out == '0);

endmodule

bind opnd_stage opnd_stage_chk #(.OPW(OPW), .NMUL(NMUL)) u_chk (
    .clk      (clk_i[0]),
    .ena      (ena_i),
    .aclr     (aclr_i),
    .scan_out (scan_out_o),
    .dly      (dly_o),
    .prod     (prod_o),
    .res      (res_o)
);

// File: tb/opnd_stage_bench.sv
module opnd_stage_bench;

    typedef struct packed {
        logic signed [17:0] a;
        logic signed [17:0] b;
        logic signed [35:0] p;
    } vec_t;

    localparam vec_t VEC [6] = '{
        '{18'sd3,       18'sd5,       36'sd15},
        '{-18'sd1,      -18'sd1,      36'sd1},
        '{18'sd131071,  18'sd131071,  36'sd17179607041},
        '{-18'sd131072, -18'sd131072, 36'sd17179869184},
        '{-18'sd131072, 18'sd131071,  -36'sd17179738112},
        '{18'sd1234,    -18'sd567,    -36'sd699678}
    };

    localparam int C [8] = '{3, -5, 7, -11, 13, -17, 19, -23};

    logic        clk = 1'b0;
    logic [3:0]  clk_v;
    logic [3:0]  ena, aclr;
    logic [71:0] b_h, b_t, a_l, b_l;
    logic [17:0] sin;
    logic        lp;
    logic [17:0] so_h, dly_h, so_t, dly_t, so_l, dly_l;
    logic [143:0] pr_h, rs_h, pr_t, rs_t, pr_l, rs_l;
    logic signed [17:0] xh [0:63];
    int total = 0;
    int bad = 0;

    always #4 clk = ~clk;
    assign clk_v = {4{clk}};

    opnd_stage u_opnd_stage (
        .clk_i(clk_v), .ena_i(ena), .aclr_i(aclr), .a_i('0), .b_i(b_h),
        .scan_in_i(sin), .b0_loop_i(lp), .scan_out_o(so_h), .dly_o(dly_h),
        .prod_o(pr_h), .res_o(rs_h));

    opnd_stage u_opnd_stage_tail (
        .clk_i(clk_v), .ena_i(ena), .aclr_i(aclr), .a_i('0), .b_i(b_t),
        .scan_in_i(so_h), .b0_loop_i(lp), .scan_out_o(so_t), .dly_o(dly_t),
        .prod_o(pr_t), .res_o(rs_t));

    opnd_stage #(.A_SHIFT(1'b0), .B0_LOOP(1'b1), .A_REG_MASK(4'b1011),
                 .B_REG_MASK(4'b0111)) u_opnd_stage_par (
        .clk_i(clk_v), .ena_i(ena), .aclr_i(aclr), .a_i(a_l), .b_i(b_l),
        .scan_in_i('0), .b0_loop_i(lp), .scan_out_o(so_l), .dly_o(dly_l),
        .prod_o(pr_l), .res_o(rs_l));

    function automatic logic signed [63:0] ln(input logic [143:0] v, input int k);
        logic signed [35:0] t;
        t = v[36*k +: 36];
        return t;
    endfunction

    function automatic logic signed [17:0] xgen(input int i);
        if (i == 5) return 18'sd131071;
        if (i == 6) return -18'sd131072;
        return 18'(((i * 7919) % 2001) - 1000);
    endfunction

    function automatic logic signed [63:0] x_at(input int n);
        if (n < 0) return 0;
        return xh[n];
    endfunction

    task automatic step();
        @(posedge clk);
        #2;
    endtask

    task automatic chk(input string tag, input logic signed [63:0] act,
                       input logic signed [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    initial begin
        #(8 * 200000);
        total++;
        bad++;
        $display("FAIL watchdog: run did not finish");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic signed [63:0] e, s, r0;
        ena = 4'b1111; aclr = 4'b0000; sin = '0; lp = 1'b0;
        a_l = '0; b_l = '0; b_h = '0; b_t = '0;
        for (int k = 0; k < 4; k++) begin
            b_h[18*k +: 18] = 18'(C[k]);
            b_t[18*k +: 18] = 18'(C[k+4]);
        end
        #1 aclr = 4'b1111;
        step(); step(); step();
        chk("R1 reset chain", $signed(so_h), 0);
        chk("R1 reset delay", $signed(dly_h), 0);
        chk("R1 reset result", ln(rs_h, 0), 0);
        chk("R1 reset product", ln(pr_l, 1), 0);
        aclr = 4'b0000;

        // R3 / R9: two chained instances against a reference FIR
        for (int i = 0; i < 40; i++) begin
            xh[i] = xgen(i);
            sin = xh[i];
            step();
            if (i + 1 >= 2) begin
                e = 0; s = 0;
                for (int j = 0; j < 8; j++) e += C[j] * x_at(i + 1 - 2 - j);
                for (int k = 0; k < 4; k++) s += ln(rs_h, k) + ln(rs_t, k);
                chk("R3 fir sum", s, e);
            end
            chk("R9 delay bank", $signed(dly_h), x_at(i + 1 - 5));
        end

        // R10 / R2: B enable low, A chain keeps moving
        ena = 4'b1101;
        b_h[17:0] = 18'd99;
        sin = 18'sd1234;
        step(); step(); step(); step();
        chk("R10 chain moves with B stalled", $signed(so_h), 1234);
        chk("R2 B bank holds", ln(pr_h, 0), 1234 * 3);
        b_h[17:0] = 18'(C[0]);
        ena = 4'b1110;
        sin = -18'sd77;
        step(); step(); step();
        chk("R2 A bank holds", $signed(so_h), 1234);
        ena = 4'b0111;
        r0 = ln(rs_h, 0);
        sin = 18'sd5;
        step(); step(); step();
        chk("R2 output bank holds", ln(rs_h, 0), r0);
        ena = 4'b1111;
        step();

        // R1: clear without a clock edge
        aclr = 4'b1001;
        #1;
        chk("R1 async clear chain", $signed(so_h), 0);
        chk("R1 async clear result", ln(rs_h, 1), 0);
        step();
        aclr = 4'b0000;

        // R4 / R5 / R7: parallel lane 1 from the vector table
        foreach (VEC[v]) begin
            a_l[18 +: 18] = VEC[v].a;
            b_l[18 +: 18] = VEC[v].b;
            step();
            chk("R5 product lane1", ln(pr_l, 1), VEC[v].p);
            step();
            chk("R7 result lane1", ln(rs_l, 1), VEC[v].p);
        end
        chk("R4 lane0 untouched", ln(pr_l, 0), 0);

        // R6: A bypass on lane 2, B bypass on lane 3
        a_l[36 +: 18] = 18'sd100; b_l[36 +: 18] = 18'sd3;
        a_l[54 +: 18] = -18'sd9;  b_l[54 +: 18] = 18'sd4;
        step();
        a_l[36 +: 18] = -18'sd250;
        b_l[54 +: 18] = 18'sd11;
        #1;
        chk("R6 A bypass lane2", ln(pr_l, 2), -750);
        chk("R6 B bypass lane3", ln(pr_l, 3), -99);
        step();

        // R8: recursion into B bank 0
        a_l[0 +: 18] = -18'sd131072;
        b_l[0 +: 18] = -18'sd131072;
        lp = 1'b0;
        step();
        chk("R8 seed product", ln(pr_l, 0), 64'sd17179869184);
        step();
        lp = 1'b1;
        b_l[0 +: 18] = 18'sd7;
        step();
        chk("R8 first recursion", ln(pr_l, 0), -64'sd8589934592);
        step();
        step();
        chk("R8 second recursion", ln(pr_l, 0), 64'sd4294967296);
        chk("R8 result lane0", ln(rs_l, 0), -64'sd8589934592);
        lp = 1'b0;

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule